// File: doc/BRIEF.md
# Fixed-Coefficient MAC Co-Processor

This block sits beside a small RV32E core and speeds up the evaluation of neurons in a multilayer perceptron. Its multipliers take no weight operand. Each one multiplies by a single model weight that is fixed when the hardware is built, so no weights are read from memory while the block runs. Weights and activations are signed 5-bit quantities.

The host sends commands as custom R-type instructions over a valid/ready channel. The funct7 field selects this unit, and funct3 selects the operation. The host first places activations in a small local buffer. It then starts the evaluation of a neuron and later reads the result back over a valid/ready response channel.

A neuron's dot product is built over one or more cycles, called chunks. A schedule table fixed at build time states, for each neuron and chunk:
- which constant multipliers take part,
- which buffered activation feeds each of them,
- whether the chunk is the neuron's last.

The accumulator starts again at each neuron. The neuron's result is stored one cycle after its last chunk.

Top module: `fcmac_core`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_valid` and `done` are 0. Every activation slot and every stored neuron result is 0.
- R2: An accepted command with funct7 = 7'h2A and funct3 = 0 writes the signed value `cmd_rs2[4:0]` into activation slot `cmd_rs1[2:0]`. It produces no response and no `done` pulse.
- R3: There are 4 constant multipliers. Multiplier k is hardwired to the weight ((7k+3) mod 31) − 15, giving −12, −5, 2 and 9. Products are signed.
- R4: Neuron n (0..3) has (n mod 4)+1 chunks. In chunk c, multiplier k takes part only when (n+c+k) mod 3 ≠ 0, and it then reads activation slot (3n+4c+k) mod 8.
- R5: The stored result of neuron n is the signed sum, over all its chunks, of the products of the participating multipliers. The full range of values is kept without overflow, including all activations at −16 or at 15.
- R6: A command with funct7 = 7'h2A and funct3 = 1 starts neuron `cmd_rs1[1:0]`. Let the accepting edge be t and the neuron have C chunks. Then `cmd_ready` is low from edge t until edge t+C+1, and `done` is high for exactly the one cycle after edge t+C+1.
- R7: A command with funct7 = 7'h2A and funct3 = 2 makes `rsp_valid` high in the cycle after the accepting edge. `rsp_data` then carries the stored result of neuron `cmd_rs1[1:0]`, sign-extended to 32 bits. The response stays valid and stable until `rsp_ready`, and `cmd_ready` is low while it is pending.
- R8: The accumulator is cleared at the start of every neuron, so evaluating the same neuron again on unchanged activations gives the same result.
- R9: A command with any other funct7, or with funct3 from 3 to 7, is accepted and ignored. It changes no activation and no result, produces no response and starts no evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered by the host |
| cmd_ready | output | 1 | Block can take a command |
| cmd_funct7 | input | 7 | funct7 of the custom instruction |
| cmd_funct3 | input | 3 | funct3 of the custom instruction (operation) |
| cmd_rs1 | input | 32 | First source register value (slot or neuron index) |
| cmd_rs2 | input | 32 | Second source register value (activation data) |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 32 | Sign-extended neuron result |
| done | output | 1 | One-cycle pulse when a neuron result is stored |

## Verification
A read response is due in the cycle right after its accepting edge. The `done` pulse for neuron n is due (n mod 4)+2 cycles after the run is accepted, and no earlier.

The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the acceptance of a run to the first edge where `done` is seen, and compares that count with the value the requirement gives. Throughout that count it also checks that `cmd_ready` stays low. Each read response is checked on the first falling edge after acceptance, and again on later edges while `rsp_ready` is held low.

// File: rtl/fcmac_core.sv
module fcmac_core #(
  parameter int M     = 4,
  parameter int NACT  = 8,
  parameter int NN    = 4,
  parameter int MAXC  = 4,
  parameter int AW    = 5,
  parameter int WW    = 5,
  parameter logic [6:0] FUNCT7 = 7'h2A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [6:0]  cmd_funct7,
  input  logic [2:0]  cmd_funct3,
  input  logic [31:0] cmd_rs1,
  input  logic [31:0] cmd_rs2,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        done
);
  localparam int IW   = $clog2(NACT);
  localparam int NW   = $clog2(NN);
  localparam int CW   = $clog2(MAXC);
  localparam int SW   = $clog2(NN * MAXC);
  localparam int NE   = NN * MAXC;
  localparam int PW   = AW + WW;
  localparam int ACCW = PW + $clog2(M * MAXC) + 1;

  function automatic logic signed [WW-1:0] wt(input int k);
    return WW'(((7 * k + 3) % 31) - 15);
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t                    st;
  logic signed [AW-1:0]   act [NACT];
  logic signed [ACCW-1:0] res [NN];
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] chunk;
  logic [NW-1:0]          cur_n;
  logic [CW-1:0]          step;
  logic [SW-1:0]          sel;
  logic [M-1:0]           rom_en   [NE];
  logic [IW-1:0]          rom_ix   [NE][M];
  logic                   rom_last [NE];
  logic signed [PW-1:0]   prod [M];
  logic                   unused_bits;

  assign unused_bits = ^{cmd_rs1, cmd_rs2};

  genvar e, k;
  generate
    for (e = 0; e < NE; e++) begin : g_rom
      localparam int EN = e / MAXC;
      localparam int EC = e % MAXC;
      assign rom_last[e] = (EC == EN % MAXC);
      for (k = 0; k < M; k++) begin : g_ent
        assign rom_en[e][k] = ((EN + EC + k) % 3) != 0;
        assign rom_ix[e][k] = IW'((3 * EN + EC * M + k) % NACT);
      end
    end
    for (k = 0; k < M; k++) begin : g_mul
      localparam logic signed [WW-1:0] W = wt(k);
      assign prod[k] = rom_en[sel][k] ? PW'(act[rom_ix[sel][k]] * W) : '0;
    end
  endgenerate

  assign sel = SW'(cur_n) * SW'(MAXC) + SW'(step);

  always_comb begin
    chunk = '0;
    for (int i = 0; i < M; i++) chunk = chunk + ACCW'(prod[i]);
  end

  wire take    = cmd_valid && cmd_ready;
  wire legal   = cmd_funct7 == FUNCT7;
  wire do_load = take && legal && cmd_funct3 == 3'd0;
  wire do_run  = take && legal && cmd_funct3 == 3'd1;
  wire do_read = take && legal && cmd_funct3 == 3'd2;

  assign cmd_ready = (st == S_IDLE) && !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      acc       <= '0;
      cur_n     <= '0;
      step      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      done      <= 1'b0;
      for (int i = 0; i < NACT; i++) act[i] <= '0;
      for (int i = 0; i < NN; i++)   res[i] <= '0;
    end else begin
      done <= 1'b0;
      if (do_load) act[cmd_rs1[IW-1:0]] <= cmd_rs2[AW-1:0];
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (do_read) begin
        rsp_valid <= 1'b1;
        rsp_data  <= 32'(res[cmd_rs1[NW-1:0]]);
      end
      case (st)
        S_IDLE: if (do_run) begin
          st    <= S_RUN;
          cur_n <= cmd_rs1[NW-1:0];
          step  <= '0;
        end
        S_RUN: begin
          acc <= (step == '0) ? chunk : acc + chunk;
          if (rom_last[sel]) st <= S_FIN;
          else               step <= step + 1'b1;
        end
        S_FIN: begin
          res[cur_n] <= acc;
          done       <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcmac_chk.sv
module fcmac_chk #(
  parameter logic [6:0] F7 = 7'h2A
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [6:0]  cmd_funct7,
  input logic [2:0]  cmd_funct3,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        done
);
  wire acc_cmd = cmd_valid && cmd_ready && cmd_funct7 == F7;

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !cmd_ready); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> cmd_ready); // R6
  AST_RUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) acc_cmd && cmd_funct3 == 3'd1 |=> !cmd_ready && !done); // R6
  AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n) acc_cmd && cmd_funct3 == 3'd0 |=> !rsp_valid && !done); // R2
  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && cmd_ready && cmd_funct7 != F7 |=> !rsp_valid && cmd_ready); // R9
endmodule

bind fcmac_core fcmac_chk #(.F7(FUNCT7)) u_chk (.*);

// File: tb/test_fcmac_core.sv
`timescale 1ns/1ps
module test_fcmac_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [6:0]  cmd_funct7 = '0;
  logic [2:0]  cmd_funct3 = '0;
  logic [31:0] cmd_rs1 = '0;
  logic [31:0] cmd_rs2 = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        done;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  logic signed [4:0] ba [8];

  localparam logic [6:0] F7 = 7'h2A;
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {4'd0, 40'h0842108421}, {4'd1, 40'hFFFFFFFFFF}, {4'd2, 40'h7BDEF7BDEF},
    {4'd3, 40'h8421084210}, {4'd3, 40'h1234567890}, {4'd2, 40'hC3A5F0E1D2},
    {4'd1, 40'h0000000000}};

  always #4 clk = ~clk;

  fcmac_core i_fcmac_core (.*);

  function automatic int wgt(int k);
    return ((7 * k + 3) % 31) - 15;
  endfunction

  function automatic int expect_res(int n);
    int s = 0;
    for (int c = 0; c <= n % 4; c++)
      for (int k = 0; k < 4; k++)
        if ((n + c + k) % 3 != 0) s += wgt(k) * int'(ba[(3 * n + 4 * c + k) % 8]);
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [6:0] f7, logic [2:0] f3, int rs1, int rs2);
    cmd_valid = 1'b1; cmd_funct7 = f7; cmd_funct3 = f3;
    cmd_rs1 = rs1; cmd_rs2 = rs2;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load_all(logic [39:0] v);
    for (int i = 0; i < 8; i++) begin
      ba[i] = v[5*i +: 5];
      issue(F7, 3'd0, i, int'(v[5*i +: 5]));
    end
  endtask

  task automatic run_n(int n);
    int cnt = 0;
    bit busy_ok = 1;
    issue(F7, 3'd1, n, 0);
    while (!done && cnt < 40) begin
      if (cmd_ready) busy_ok = 0;
      @(negedge clk);
      cnt++;
    end
    chk(cnt == n % 4 + 2, "R6 done latency", cnt, n % 4 + 2);
    chk(busy_ok, "R6 ready low while busy", 0, 1);
    @(negedge clk);
    chk(!done, "R6 done single pulse", int'(done), 0);
  endtask

  task automatic read_n(int n, int exp, string req);
    issue(F7, 3'd2, n, 0);
    chk(rsp_valid && $signed(rsp_data) == exp, req, $signed(rsp_data), exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ba[i] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !rsp_valid && !done, "R1 reset outputs", int'({cmd_ready, rsp_valid, done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    read_n(2, 0, "R1 reset result");
    run_n(3);
    read_n(3, 0, "R1 zero activations");

    // table: load, run, read; R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      load_all(VEC[v][39:0]);
      chk(!rsp_valid, "R2 load gives no response", int'(rsp_valid), 0);
      run_n(int'(VEC[v][43:40]));
      read_n(int'(VEC[v][43:40]), expect_res(int'(VEC[v][43:40])), "R5 neuron result R3 R4");
    end

    // R8: rerun same neuron
    run_n(2);
    read_n(2, expect_res(2), "R8 accumulator cleared");

    // R7: hold response
    issue(F7, 3'd2, 2, 0);
    for (int i = 0; i < 3; i++) begin
      chk(rsp_valid && !cmd_ready && $signed(rsp_data) == expect_res(2), "R7 response held",
          $signed(rsp_data), expect_res(2));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready, "R7 response released", int'(rsp_valid), 0);

    // R9: ignored commands
    issue(F7, 3'd5, 0, 0);
    chk(!rsp_valid && cmd_ready && !done, "R9 funct3 ignored", int'(rsp_valid), 0);
    issue(7'h11, 3'd0, 0, 9);
    issue(7'h11, 3'd0, 1, 9);
    issue(7'h11, 3'd1, 1, 0);
    chk(cmd_ready && !done, "R9 run with wrong funct7", int'(cmd_ready), 1);
    issue(7'h11, 3'd2, 1, 0);
    chk(!rsp_valid, "R9 read with wrong funct7", int'(rsp_valid), 0);
    run_n(1);
    read_n(1, expect_res(1), "R9 activations unchanged");
    read_n(2, expect_res(2), "R9 results unchanged");

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule